// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block sits between a host controller's register file and a bit-level I2C engine. When the register block signals a start, the sequencer samples the selected protocol, the slave address byte, the command byte and the two data bytes. It then runs the matching series of byte-level bus primitives through a valid/ready request port. The primitives are start, repeated start, write, read with ACK, read with NACK, and stop. Each primitive returns one response that carries an acknowledge flag, a bus-failure flag and a read byte.

Read results go back to the register block as write strobes for data0, data1 and the block-data byte. Completion goes back as one-cycle set pulses for the status bits: interrupt, device error, and byte-done-with-host-busy. The block-data protocol involves no bus activity here. It only raises a hand-off pulse for the separate block buffer engine. The I2C block read is different from the others: it leaves the bus open after the first byte so that the buffer engine can continue the transfer.

Top module: `smbus_txn_seq`

## Requirements
- R1: `proto_sel` is sampled when `start` is accepted in idle. Codes are 0 quick, 1 byte, 2 byte data, 3 word data, 4 process call, 5 block data, 6 I2C block read, 7 reserved.
- R2: Address byte bit 0 is the direction (1 = read) and bits 7:1 hold the 7-bit slave address. A quick command issues start with the address byte unchanged, then stop, and then pulses `sts_intr`.
- R3: Byte write sends start(addr,W), write(cmd), stop. Byte read sends start(addr,R), read-NACK, stop, and the read byte is strobed with `res_d0_we`.
- R4: Byte-data write sends start(W), cmd, data0, stop. Byte-data read sends start(W), cmd, repeated start(R), read-NACK into data0, stop.
- R5: Word write sends start(W), cmd, data0, data1, stop. Word read sends start(W), cmd, repeated start(R), read-ACK into data0, read-NACK into data1, stop.
- R6: I2C block read sends start(W), then data1, then repeated start(R), then read-ACK, whatever the direction bit. The byte is strobed with `res_blk_we`, `sts_byte_done` pulses, and no stop is issued.
- R7: A NACK on a start, repeated start or write step, or a failure flag on any non-stop step, aborts the sequence. Stop is issued next and `sts_dev_err` pulses. A failure flag on the closing stop gives `sts_dev_err` instead of `sts_intr`. Aborted reads strobe nothing.
- R8: Codes 4 and 7 pulse `sts_dev_err` one cycle after start and issue no primitive.
- R9: Code 5 pulses `blk_handoff` one cycle after start and issues no primitive.
- R10: Request opcodes are 0 start, 1 repeated start, 2 write, 3 read-ACK, 4 read-NACK, 5 stop. A request holds opcode and byte while not ready. At most one primitive is outstanding, and no request is raised while `busy` is low.
- R11: `start` while busy is ignored. Register inputs changed after the accepted start do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start request from the register block |
| proto_sel | input | 3 | Protocol code (control bits 4:2) |
| addr_reg | input | 8 | Slave address and direction byte |
| cmd_reg | input | 8 | Command byte |
| data0_reg | input | 8 | Data byte 0 |
| data1_reg | input | 8 | Data byte 1 |
| busy | output | 1 | Sequence in progress |
| req_valid | output | 1 | Primitive request valid |
| req_ready | input | 1 | Engine accepts request |
| req_op | output | 3 | Primitive opcode |
| req_byte | output | 8 | Byte for start or write |
| rsp_valid | input | 1 | Primitive response valid |
| rsp_ack | input | 1 | Slave acknowledged |
| rsp_fail | input | 1 | Bus failure on this primitive |
| rsp_data | input | 8 | Byte read |
| res_data | output | 8 | Result byte |
| res_d0_we | output | 1 | Write result into data0 |
| res_d1_we | output | 1 | Write result into data1 |
| res_blk_we | output | 1 | Write result into block-data byte |
| sts_intr | output | 1 | Set interrupt status |
| sts_dev_err | output | 1 | Set device error status |
| sts_byte_done | output | 1 | Set byte-done and host-busy status |
| blk_handoff | output | 1 | Start block buffer engine |

## Verification
A corrupted step index or latched protocol shows up as a wrong opcode or byte at the request port. It appears on the very next request after the fault, so the logged primitive list per transaction pins it down. A stuck abort state or a mis-decoded NACK appears as a missing or extra stop and as the wrong completion pulse within one response of the failing step. A bad destination select is seen as a strobe on the wrong data register at the read response. The sweep covers every protocol, both directions, and a NACK or failure at every step position, with and without back-pressure.

// File: rtl/smbseq_pkg.sv
// Package: shared types for the SMBus transaction sequencer.
// Assumes byte-wide bus primitives and at most eight steps per sequence.
package smbseq_pkg;

    localparam int BYTE_W = 8;

    localparam logic [2:0] PROTO_QUICK  = 3'd0;
    localparam logic [2:0] PROTO_BYTE   = 3'd1;
    localparam logic [2:0] PROTO_BDATA  = 3'd2;
    localparam logic [2:0] PROTO_WORD   = 3'd3;
    localparam logic [2:0] PROTO_PCALL  = 3'd4;
    localparam logic [2:0] PROTO_BLOCK  = 3'd5;
    localparam logic [2:0] PROTO_I2CBLK = 3'd6;
    localparam logic [2:0] PROTO_RSVD   = 3'd7;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RSTART  = 3'd1,
        OP_WRITE   = 3'd2,
        OP_RD_ACK  = 3'd3,
        OP_RD_NACK = 3'd4,
        OP_STOP    = 3'd5
    } prim_op_e;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_ADDR_RAW, SRC_ADDR_W, SRC_ADDR_R, SRC_CMD, SRC_D0, SRC_D1
    } src_e;

    typedef enum logic [1:0] {DST_NONE, DST_D0, DST_D1, DST_BLK} dst_e;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_ABORT} seq_state_e;

    typedef struct packed {
        prim_op_e op;
        src_e     src;
        dst_e     dst;
        logic     open_end;
    } step_t;

    // Builds one step descriptor.
    function automatic step_t mk(prim_op_e op, src_e src, dst_e dst, logic open_end);
        step_t s;
        s.op       = op;
        s.src      = src;
        s.dst      = dst;
        s.open_end = open_end;
        return s;
    endfunction

endpackage

// File: rtl/smbseq_step_rom.sv
// Step table: maps (protocol, direction, step index) to the primitive to
// issue, where its byte comes from and where a read result goes.
// Assumes rejected and hand-off protocols never reach it; any index past a
// sequence's body yields the closing stop.
module smbseq_step_rom
    import smbseq_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic [2:0]        proto,
    input  logic              dir,
    input  logic [STEP_W-1:0] idx,
    output step_t             step
);

    // Combinational table lookup.
    always_comb begin
        int i;
        i = int'(idx);
        step = mk(OP_STOP, SRC_NONE, DST_NONE, 1'b0);
        case (proto)
            PROTO_QUICK: begin
                if (i == 0) step = mk(OP_START, SRC_ADDR_RAW, DST_NONE, 1'b0);
            end
            PROTO_BYTE: begin
                if (dir) begin
                    case (i)
                        0: step = mk(OP_START, SRC_ADDR_R, DST_NONE, 1'b0);
                        1: step = mk(OP_RD_NACK, SRC_NONE, DST_D0, 1'b0);
                        default: ;
                    endcase
                end else begin
                    case (i)
                        0: step = mk(OP_START, SRC_ADDR_W, DST_NONE, 1'b0);
                        1: step = mk(OP_WRITE, SRC_CMD, DST_NONE, 1'b0);
                        default: ;
                    endcase
                end
            end
            PROTO_BDATA, PROTO_WORD: begin
                case (i)
                    0: step = mk(OP_START, SRC_ADDR_W, DST_NONE, 1'b0);
                    1: step = mk(OP_WRITE, SRC_CMD, DST_NONE, 1'b0);
                    2: step = dir ? mk(OP_RSTART, SRC_ADDR_R, DST_NONE, 1'b0)
                                  : mk(OP_WRITE, SRC_D0, DST_NONE, 1'b0);
                    3: begin
                        if (proto == PROTO_WORD)
                            step = dir ? mk(OP_RD_ACK, SRC_NONE, DST_D0, 1'b0)
                                       : mk(OP_WRITE, SRC_D1, DST_NONE, 1'b0);
                        else if (dir)
                            step = mk(OP_RD_NACK, SRC_NONE, DST_D0, 1'b0);
                    end
                    4: begin
                        if (proto == PROTO_WORD && dir)
                            step = mk(OP_RD_NACK, SRC_NONE, DST_D1, 1'b0);
                    end
                    default: ;
                endcase
            end
            PROTO_I2CBLK: begin
                case (i)
                    0: step = mk(OP_START, SRC_ADDR_W, DST_NONE, 1'b0);
                    1: step = mk(OP_WRITE, SRC_D1, DST_NONE, 1'b0);
                    2: step = mk(OP_RSTART, SRC_ADDR_R, DST_NONE, 1'b0);
                    3: step = mk(OP_RD_ACK, SRC_NONE, DST_BLK, 1'b1);
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/smbseq_prim_if.sv
// Primitive port: turns a one-cycle issue pulse into a held valid/ready
// request, waits for the single response and returns it as a one-cycle
// finish pulse with registered flags and data.
// Assumes the caller issues only when no primitive is outstanding.
module smbseq_prim_if
    import smbseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [2:0]        issue_op,
    input  logic [BYTE_W-1:0] issue_byte,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [2:0]        req_op,
    output logic [BYTE_W-1:0] req_byte,
    input  logic              rsp_valid,
    input  logic              rsp_ack,
    input  logic              rsp_fail,
    input  logic [BYTE_W-1:0] rsp_data,
    output logic              fin,
    output logic              fin_ack,
    output logic              fin_fail,
    output logic [BYTE_W-1:0] fin_data
);

    logic waiting_q;

    // Request/response tracking for a single outstanding primitive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_op    <= '0;
            req_byte  <= '0;
            waiting_q <= 1'b0;
            fin       <= 1'b0;
            fin_ack   <= 1'b0;
            fin_fail  <= 1'b0;
            fin_data  <= '0;
        end else begin
            fin <= 1'b0;
            if (issue && !req_valid && !waiting_q) begin
                req_valid <= 1'b1;
                req_op    <= issue_op;
                req_byte  <= issue_byte;
            end else if (req_valid && req_ready) begin
                req_valid <= 1'b0;
                waiting_q <= 1'b1;
            end else if (waiting_q && rsp_valid) begin
                waiting_q <= 1'b0;
                fin       <= 1'b1;
                fin_ack   <= rsp_ack;
                fin_fail  <= rsp_fail;
                fin_data  <= rsp_data;
            end
        end
    end

endmodule

// File: rtl/smbus_txn_seq.sv
// SMBus host transaction sequencer. On an accepted start it latches the
// protocol and register bytes and steps through the table, issuing one
// primitive at a time. It aborts with a stop on NACK or bus failure, and
// reports completion as one-cycle status set pulses.
// Assumes the register block keeps the status bits and the data registers.
module smbus_txn_seq
    import smbseq_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        proto_sel,
    input  logic [BYTE_W-1:0] addr_reg,
    input  logic [BYTE_W-1:0] cmd_reg,
    input  logic [BYTE_W-1:0] data0_reg,
    input  logic [BYTE_W-1:0] data1_reg,
    output logic              busy,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [2:0]        req_op,
    output logic [BYTE_W-1:0] req_byte,
    input  logic              rsp_valid,
    input  logic              rsp_ack,
    input  logic              rsp_fail,
    input  logic [BYTE_W-1:0] rsp_data,
    output logic [BYTE_W-1:0] res_data,
    output logic              res_d0_we,
    output logic              res_d1_we,
    output logic              res_blk_we,
    output logic              sts_intr,
    output logic              sts_dev_err,
    output logic              sts_byte_done,
    output logic              blk_handoff
);

    seq_state_e        state_q;
    logic [2:0]        proto_q;
    logic [BYTE_W-1:0] addr_q, cmd_q, d0_q, d1_q;
    logic [STEP_W-1:0] idx_q;
    logic              kick_q;
    step_t             cur;
    logic [BYTE_W-1:0] step_byte;
    prim_op_e          issue_op;
    logic              fin, fin_ack, fin_fail;
    logic [BYTE_W-1:0] fin_data;
    logic              addr_or_wr, step_bad;

    smbseq_step_rom #(.STEP_W(STEP_W)) u_rom (
        .proto (proto_q),
        .dir   (addr_q[0]),
        .idx   (idx_q),
        .step  (cur)
    );

    // Byte source select for the current step.
    always_comb begin
        case (cur.src)
            SRC_ADDR_RAW: step_byte = addr_q;
            SRC_ADDR_W:   step_byte = {addr_q[BYTE_W-1:1], 1'b0};
            SRC_ADDR_R:   step_byte = {addr_q[BYTE_W-1:1], 1'b1};
            SRC_CMD:      step_byte = cmd_q;
            SRC_D0:       step_byte = d0_q;
            SRC_D1:       step_byte = d1_q;
            default:      step_byte = '0;
        endcase
    end

    // The abort path always closes the bus with a stop.
    assign issue_op = (state_q == ST_ABORT) ? OP_STOP : cur.op;

    smbseq_prim_if u_prim (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (kick_q),
        .issue_op   (issue_op),
        .issue_byte ((state_q == ST_ABORT) ? '0 : step_byte),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_byte   (req_byte),
        .rsp_valid  (rsp_valid),
        .rsp_ack    (rsp_ack),
        .rsp_fail   (rsp_fail),
        .rsp_data   (rsp_data),
        .fin        (fin),
        .fin_ack    (fin_ack),
        .fin_fail   (fin_fail),
        .fin_data   (fin_data)
    );

    // Classify the finished step: addressing and writes need an ACK.
    assign addr_or_wr = (cur.op == OP_START) || (cur.op == OP_RSTART) || (cur.op == OP_WRITE);
    assign step_bad   = fin_fail || (addr_or_wr && !fin_ack);
    assign busy       = (state_q != ST_IDLE);

    // Sequencing, result strobes and status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            proto_q       <= '0;
            addr_q        <= '0;
            cmd_q         <= '0;
            d0_q          <= '0;
            d1_q          <= '0;
            idx_q         <= '0;
            kick_q        <= 1'b0;
            res_data      <= '0;
            res_d0_we     <= 1'b0;
            res_d1_we     <= 1'b0;
            res_blk_we    <= 1'b0;
            sts_intr      <= 1'b0;
            sts_dev_err   <= 1'b0;
            sts_byte_done <= 1'b0;
            blk_handoff   <= 1'b0;
        end else begin
            kick_q        <= 1'b0;
            res_d0_we     <= 1'b0;
            res_d1_we     <= 1'b0;
            res_blk_we    <= 1'b0;
            sts_intr      <= 1'b0;
            sts_dev_err   <= 1'b0;
            sts_byte_done <= 1'b0;
            blk_handoff   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        proto_q <= proto_sel;
                        addr_q  <= addr_reg;
                        cmd_q   <= cmd_reg;
                        d0_q    <= data0_reg;
                        d1_q    <= data1_reg;
                        idx_q   <= '0;
                        case (proto_sel)
                            PROTO_PCALL, PROTO_RSVD: sts_dev_err <= 1'b1;
                            PROTO_BLOCK:             blk_handoff <= 1'b1;
                            default: begin
                                state_q <= ST_RUN;
                                kick_q  <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_RUN: begin
                    if (fin) begin
                        if (cur.op == OP_STOP) begin
                            sts_intr    <= !fin_fail;
                            sts_dev_err <= fin_fail;
                            state_q     <= ST_IDLE;
                        end else if (step_bad) begin
                            state_q <= ST_ABORT;
                            kick_q  <= 1'b1;
                        end else begin
                            res_data   <= fin_data;
                            res_d0_we  <= (cur.dst == DST_D0);
                            res_d1_we  <= (cur.dst == DST_D1);
                            res_blk_we <= (cur.dst == DST_BLK);
                            if (cur.open_end) begin
                                sts_byte_done <= 1'b1;
                                state_q       <= ST_IDLE;
                            end else begin
                                idx_q  <= idx_q + 1'b1;
                                kick_q <= 1'b1;
                            end
                        end
                    end
                end
                ST_ABORT: begin
                    if (fin) begin
                        sts_dev_err <= 1'b1;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/smbseq_chk.sv
// Checker for smbus_txn_seq: handshake rules, completion exclusivity and
// the no-bus protocols. Attached by bind below.
module smbseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [2:0] proto_sel,
    input logic       busy,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] req_op,
    input logic [7:0] req_byte,
    input logic       res_d0_we,
    input logic       res_d1_we,
    input logic       sts_intr,
    input logic       sts_dev_err,
    input logic       sts_byte_done,
    input logic       blk_handoff
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_byte)); // R10

    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid); // R10

    AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_op <= 3'd5); // R10

    AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sts_intr, sts_dev_err, sts_byte_done, blk_handoff})); // R7

    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_intr || sts_dev_err || sts_byte_done || blk_handoff) |-> !busy); // R2

    AST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && (proto_sel == 3'd4 || proto_sel == 3'd7) |=> sts_dev_err && !busy); // R8

    AST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && proto_sel == 3'd5 |=> blk_handoff && !busy); // R9

    AST_WE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (res_d0_we || res_d1_we) |-> busy); // R5

endmodule

bind smbus_txn_seq smbseq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .proto_sel     (proto_sel),
    .busy          (busy),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_op        (req_op),
    .req_byte      (req_byte),
    .res_d0_we     (res_d0_we),
    .res_d1_we     (res_d1_we),
    .sts_intr      (sts_intr),
    .sts_dev_err   (sts_dev_err),
    .sts_byte_done (sts_byte_done),
    .blk_handoff   (blk_handoff)
);

// File: tb/smbus_txn_seq_bench.sv
// Sweeps every protocol, both directions, and a NACK or failure at every
// step, against a bench-side expected primitive list.
module smbus_txn_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] proto_sel = '0;
    logic [7:0] addr_reg = '0, cmd_reg = '0, data0_reg = '0, data1_reg = '0;
    logic       busy, req_valid, req_ready = 1'b0;
    logic [2:0] req_op;
    logic [7:0] req_byte;
    logic       rsp_valid = 1'b0, rsp_ack = 1'b0, rsp_fail = 1'b0;
    logic [7:0] rsp_data = '0;
    logic [7:0] res_data;
    logic       res_d0_we, res_d1_we, res_blk_we;
    logic       sts_intr, sts_dev_err, sts_byte_done, blk_handoff;

    always #4 clk = ~clk;

    smbus_txn_seq u_smbus_txn_seq (.*);

    int n_tests = 0, n_fail = 0, cyc = 0;
    int nack_at = 99, fail_at = 99, slow = 0;
    int nops = 0, pend = 0, cur_i = 0, overlap = 0;
    int log_op[16], log_byte[16];
    int n_intr, n_err, n_bd, n_ho, n_d0, n_d1, n_blk;
    int g_d0, g_d1, g_blk;
    int exp_op[16], exp_byte[16], exp_dst[16], exp_n;

    function automatic int rdat(int i);
        return (8'hC3 ^ (i * 29)) & 8'hFF;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Responder, back-pressure and output monitor, all away from the active edge.
    always @(negedge clk) begin
        bit r;
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
        rsp_valid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                rsp_valid = 1'b1;
                rsp_ack   = (cur_i != nack_at);
                rsp_fail  = (cur_i == fail_at);
                rsp_data  = 8'(rdat(cur_i));
            end
        end
        r = slow ? ((cyc % 3) != 1) : 1'b1;
        req_ready = r;
        if (req_valid && r) begin
            if (pend != 0) overlap++;
            if (nops < 16) begin
                log_op[nops] = int'(req_op);
                log_byte[nops] = int'(req_byte);
            end
            cur_i = nops;
            nops++;
            pend = 2;
        end
        if (sts_intr) n_intr++;
        if (sts_dev_err) n_err++;
        if (sts_byte_done) n_bd++;
        if (blk_handoff) n_ho++;
        if (res_d0_we) begin n_d0++; g_d0 = res_data; end
        if (res_d1_we) begin n_d1++; g_d1 = res_data; end
        if (res_blk_we) begin n_blk++; g_blk = res_data; end
    end

    task automatic push(input int op, input int b, input int dst);
        exp_op[exp_n] = op; exp_byte[exp_n] = b; exp_dst[exp_n] = dst; exp_n++;
    endtask

    // Expected primitive list from the protocol definitions.
    task automatic build(input int p, input int d, input int a, input int c, input int x0, input int x1);
        int aw, ar;
        aw = a & 8'hFE; ar = a | 1;
        exp_n = 0;
        case (p)
            0: begin push(0, a, 0); push(5, 0, 0); end
            1: if (d != 0) begin push(0, ar, 0); push(4, 0, 1); push(5, 0, 0); end
               else begin push(0, aw, 0); push(2, c, 0); push(5, 0, 0); end
            2: begin
                push(0, aw, 0); push(2, c, 0);
                if (d != 0) begin push(1, ar, 0); push(4, 0, 1); end else push(2, x0, 0);
                push(5, 0, 0);
            end
            3: begin
                push(0, aw, 0); push(2, c, 0);
                if (d != 0) begin push(1, ar, 0); push(3, 0, 1); push(4, 0, 2); end
                else begin push(2, x0, 0); push(2, x1, 0); end
                push(5, 0, 0);
            end
            6: begin push(0, aw, 0); push(2, x1, 0); push(1, ar, 0); push(3, 0, 3); end
            default: ;
        endcase
    endtask

    task automatic run_txn(input int p, input int d, input int k, input string tag, input bit disturb);
        int a, c, x0, x1, t, kind, fo, mism;
        int xd0, xd1, xblk, en0, en1, enb;
        a = ((8'h20 + (k % 90)) << 1) | d; c = (8'h40 + k) & 8'hFF;
        x0 = (8'h81 + 3 * k) & 8'hFF; x1 = (8'h17 + 5 * k) & 8'hFF;
        build(p, d, a, c, x0, x1);
        // Apply the injected fault to the expected list.
        kind = (p == 6) ? 2 : 0; fo = exp_n;
        en0 = 0; en1 = 0; enb = 0; xd0 = 0; xd1 = 0; xblk = 0;
        if (p == 4 || p == 7) kind = 1;
        if (p == 5) kind = 3;
        for (int i = 0; i < exp_n; i++) begin
            bit aw;
            aw = (exp_op[i] <= 2);
            if (i == fail_at || (i == nack_at && aw)) begin
                kind = 1;
                if (exp_op[i] == 5) fo = i + 1;
                else begin fo = i + 2; exp_op[i+1] = 5; exp_byte[i+1] = 0; end
                break;
            end
            if (exp_dst[i] == 1) begin en0 = 1; xd0 = rdat(i); end
            if (exp_dst[i] == 2) begin en1 = 1; xd1 = rdat(i); end
            if (exp_dst[i] == 3) begin enb = 1; xblk = rdat(i); end
        end
        nops = 0; n_intr = 0; n_err = 0; n_bd = 0; n_ho = 0; n_d0 = 0; n_d1 = 0; n_blk = 0;
        proto_sel = 3'(p); addr_reg = 8'(a); cmd_reg = 8'(c); data0_reg = 8'(x0); data1_reg = 8'(x1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while ((n_intr + n_err + n_bd + n_ho) == 0 && t < 300) begin
            @(negedge clk);
            t++;
            if (disturb && t == 6) begin
                start = 1'b1; proto_sel = 3'd0; addr_reg = ~addr_reg;
                cmd_reg = ~cmd_reg; data0_reg = 8'h00; data1_reg = 8'hFF;
            end
            if (disturb && t == 7) start = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk(t < 300, {tag, " completion seen"}, t, 0);
        chk(nops == fo, {tag, " primitive count"}, nops, fo);
        mism = 0;
        for (int i = 0; i < fo && i < nops && i < 16; i++)
            if (log_op[i] != exp_op[i] || (exp_op[i] <= 2 && log_byte[i] != exp_byte[i])) mism++;
        chk(mism == 0, {tag, " R10 opcode/byte sequence"}, mism, 0);
        chk(n_intr == (kind == 0) && n_err == (kind == 1) && n_bd == (kind == 2) && n_ho == (kind == 3),
            {tag, " completion kind"}, {n_intr[3:0], n_err[3:0], n_bd[3:0], n_ho[3:0]}, kind);
        chk(n_d0 == en0 && (en0 == 0 || g_d0 == xd0), {tag, " data0 result"}, g_d0, xd0);
        chk(n_d1 == en1 && (en1 == 0 || g_d1 == xd1), {tag, " data1 result"}, g_d1, xd1);
        chk(n_blk == enb && (enb == 0 || g_blk == xblk), {tag, " block byte result"}, g_blk, xblk);
    endtask

    function automatic string ptag(int p);
        case (p)
            0: return "R2 quick";
            1: return "R3 byte";
            2: return "R4 byte-data";
            3: return "R5 word";
            6: return "R6 i2c-block-read";
            5: return "R9 block hand-off";
            default: return "R8 rejected";
        endcase
    endfunction

    initial begin
        int k;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R10 reset busy", busy, 0);
        chk(req_valid == 1'b0, "R10 reset no request", req_valid, 0);
        chk((n_intr + n_err + n_bd + n_ho) == 0, "R1 reset no status", n_intr + n_err, 0);
        k = 0;
        for (int p = 0; p < 8; p++) begin
            for (int d = 0; d < 2; d++) begin
                slow = k % 2;
                nack_at = 99; fail_at = 99;
                run_txn(p, d, k, {"R1 ", ptag(p)}, 1'b0);
                k++;
                for (int f = 0; f < 14; f++) begin
                    slow = (k + f) % 2;
                    if (f < 7) begin nack_at = f; fail_at = 99; end
                    else begin nack_at = 99; fail_at = f - 7; end
                    run_txn(p, d, k, "R7 fault", 1'b0);
                    k++;
                end
            end
        end
        nack_at = 99; fail_at = 99; slow = 1;
        run_txn(3, 1, 7, "R11 start-while-busy", 1'b1);
        run_txn(2, 0, 9, "R11 start-while-busy", 1'b1);
        chk(overlap == 0, "R10 one outstanding", overlap, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule